// File: doc/BRIEF.md
# MDIO Management Register Controller

This block lets a processor run Clause-22 management reads and writes on the serial management bus of an external PHY. Software writes one 32-bit command word that holds the operation, the PHY address, the register address and, for a write, the data. The controller then generates the management clock, shifts out a 64-bit frame, and reports progress in the same word. The word shows a busy flag, and after a read it shows a read-valid flag next to the returned data.

A separate cause register reports events. One bit is set when a transaction completes. Another bit is set when an external link-status input changes value. Software clears bits by writing zeros to them. Only one command runs at a time. A new command is accepted only while the controller is idle.

The management clock is the system clock divided by an even parameter, `MDC_DIV`. The controller changes MDIO when MDC falls and samples MDIO when MDC rises. MDIO is handled as three plain pins (out, output enable, in), so the pad can be placed outside the block.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command word reads 0, the cause register reads 0, MDC is low and the MDIO output enable is low.
- R2: While a transaction runs, MDC has a period of exactly `MDC_DIV` clocks. Busy stays set for exactly 64*`MDC_DIV` clocks after the command is accepted. MDC is low whenever the controller is idle.
- R3: A write frame sends, MSB first, 32 ones, start code 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10 and the 16 data bits. The output enable is high for all 64 bits. MDIO changes only when MDC falls.
- R4: A read frame sends 32 ones, start code 01, opcode 10, the PHY address and the register address, with the output enable high for those 46 bits. The controller releases MDIO (output enable low) for the two turnaround bits and the 16 data bits. It samples the data on rising MDC, MSB first.
- R5: The command word reads back as follows: bit 28 is busy, bit 27 is read-valid, bit 26 is the operation (1 = read, 0 = write), bits 25:21 are the register address, bits 20:16 are the PHY address and bits 15:0 are the data. Bits 31:29 read 0. When a read completes, bit 27 sets and bits 15:0 hold the sampled data.
- R6: A command write while busy is set is ignored. The fields, the frame and the transaction length all stay those of the running command.
- R7: Read-valid clears when a new command is accepted. It stays 0 after a write completes.
- R8: Completion of a transaction sets cause bit 29. The bit is set on the same clock edge where busy clears.
- R9: A change of `link_i` in either direction sets cause bit 28 one clock later. The change is compared with the previous sampled value, which reset makes 0.
- R10: A cause write clears each bit written 0 and keeps each bit written 1, so writing zero clears all pending causes. An event on the same edge still sets its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Write strobe for the command word |
| cmd_wdata_i | input | 32 | Command word write data |
| cmd_rdata_o | output | 32 | Command and status word read data |
| cause_wr_i | input | 1 | Write strobe for the cause register |
| cause_wdata_i | input | 32 | Cause write data (0 clears a bit, 1 keeps it) |
| cause_rdata_o | output | 32 | Cause register read data |
| link_i | input | 1 | External link-status level |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input data |

## Verification
A command written before a clock edge shows busy and its fields at the next falling clock. Busy is then counted on every falling clock until it clears, and the count must equal 64*`MDC_DIV`. Read data, read-valid and the completion cause appear on the same edge where busy clears, so the bench checks them at the first falling clock after busy reads 0. The frame is recorded at each rising edge of MDC, when MDIO has been stable for half an MDC period. A link change made at a falling clock is checked at the following falling clock, which is one register later.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS);
  localparam int unsigned TA_POS     = 46;
  localparam int unsigned DATA_POS   = 48;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned DATA_W     = 16;

  localparam int unsigned ST_BUSY  = 28;
  localparam int unsigned ST_VALID = 27;
  localparam int unsigned ST_OP    = 26;
  localparam int unsigned CA_DONE  = 29;
  localparam int unsigned CA_LINK  = 28;

  localparam logic [1:0] SOF     = 2'b01;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] TA_WR   = 2'b10;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic              rd,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rg,
    input logic [DATA_W-1:0] dat);
    logic [FRAME_BITS-1:0] f;
    f = {32'hFFFF_FFFF, SOF, (rd ? OP_RD : OP_WR), phy, rg,
         (rd ? 2'b11 : TA_WR), (rd ? {DATA_W{1'b1}} : dat)};
    return f;
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  logic edge_now;

  generate
    if (HALF == 1) begin : g_direct
      assign edge_now = active;
    end else begin : g_count
      localparam int unsigned CW = $clog2(HALF);
      logic [CW-1:0] cnt_q;
      assign edge_now = active && (cnt_q == CW'(HALF - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!active)  cnt_q <= '0;
        else if (edge_now) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mdc <= 1'b0;
    else if (!active)  mdc <= 1'b0;
    else if (edge_now) mdc <= ~mdc;
  end

  assign rise_evt = edge_now && !mdc;
  assign fall_evt = edge_now &&  mdc;

  p_mdc_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic [ADDR_W-1:0] start_phy,
  input  logic [ADDR_W-1:0] start_reg,
  input  logic [DATA_W-1:0] start_data,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_in,
  output logic              busy,
  output logic              done,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data
);
  logic [FRAME_BITS-1:0] sh_q;
  logic [CNT_W-1:0]      bit_q;
  logic                  rd_q;
  logic                  last_bit;

  assign last_bit = (bit_q == CNT_W'(FRAME_BITS - 1));
  assign done     = busy && fall_evt && last_bit;
  assign mdio_out = sh_q[FRAME_BITS-1];
  assign mdio_oe  = busy && !(rd_q && (bit_q >= CNT_W'(TA_POS)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      bit_q   <= '0;
      rd_q    <= 1'b0;
      busy    <= 1'b0;
      rd_data <= '0;
    end else if (!busy) begin
      if (start) begin
        sh_q    <= build_frame(start_rd, start_phy, start_reg, start_data);
        bit_q   <= '0;
        rd_q    <= start_rd;
        busy    <= 1'b1;
        rd_data <= '0;
      end
    end else begin
      if (rise_evt && rd_q && (bit_q >= CNT_W'(DATA_POS)))
        rd_data <= {rd_data[DATA_W-2:0], mdio_in};
      if (fall_evt) begin
        if (last_bit) begin
          busy <= 1'b0;
          sh_q <= '0;
        end else begin
          sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  p_mdio_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_out)) |-> $past(fall_evt));
  p_oe_only_at_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $rose(busy));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned MDC_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr_i,
  input  logic [31:0] cmd_wdata_i,
  output logic [31:0] cmd_rdata_o,
  input  logic        cause_wr_i,
  input  logic [31:0] cause_wdata_i,
  output logic [31:0] cause_rdata_o,
  input  logic        link_i,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int unsigned HALF = MDC_DIV / 2;

  logic              busy, done, rise_evt, fall_evt, accept;
  logic [DATA_W-1:0] eng_rd_data;
  logic              op_q, valid_q, link_q, c_done_q, c_link_q;
  logic [ADDR_W-1:0] phy_q, reg_q;
  logic [DATA_W-1:0] data_q;
  logic              unused_bits;

  assign unused_bits = ^{cmd_wdata_i[31:27], cause_wdata_i[31:30],
                         cause_wdata_i[27:0]};
  assign accept = cmd_wr_i && !busy;

  mdio_clk_div #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .active(busy),
    .mdc(mdc_o), .rise_evt(rise_evt), .fall_evt(fall_evt));

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .start_rd(cmd_wdata_i[ST_OP]),
    .start_phy(cmd_wdata_i[20:16]), .start_reg(cmd_wdata_i[25:21]),
    .start_data(cmd_wdata_i[15:0]),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_in(mdio_i),
    .busy(busy), .done(done), .mdio_out(mdio_o), .mdio_oe(mdio_oe_o),
    .rd_data(eng_rd_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (accept) begin
      op_q    <= cmd_wdata_i[ST_OP];
      reg_q   <= cmd_wdata_i[25:21];
      phy_q   <= cmd_wdata_i[20:16];
      data_q  <= cmd_wdata_i[15:0];
      valid_q <= 1'b0;
    end else if (done && op_q) begin
      data_q  <= eng_rd_data;
      valid_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q   <= 1'b0;
      c_done_q <= 1'b0;
      c_link_q <= 1'b0;
    end else begin
      link_q   <= link_i;
      c_done_q <= (cause_wr_i ? (c_done_q & cause_wdata_i[CA_DONE]) : c_done_q) | done;
      c_link_q <= (cause_wr_i ? (c_link_q & cause_wdata_i[CA_LINK]) : c_link_q)
                  | (link_i != link_q);
    end
  end

  assign cmd_rdata_o   = {3'b000, busy, valid_q, op_q, reg_q, phy_q, data_q};
  assign cause_rdata_o = {2'b00, c_done_q, c_link_q, 28'h0};

  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && busy) |=> ($stable(op_q) && $stable(phy_q) && $stable(reg_q)));
  p_read_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q) |=> valid_q);
  p_valid_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !valid_q);
  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> c_done_q);
  p_link_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (link_i != link_q) |=> c_link_q);
endmodule

// File: tb/mdio_mgmt_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb_top;
  localparam int unsigned DIV = 4;
  localparam int unsigned NV  = 5;
  // {read, phy, reg, wdata, phy response}
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 5'd1,  5'd0,  16'h1200, 16'h0000},
    {1'b1, 5'd5,  5'd2,  16'h0000, 16'h0141},
    {1'b0, 5'd31, 5'd31, 16'hFFFF, 16'h0000},
    {1'b1, 5'd0,  5'd1,  16'h0000, 16'h8001},
    {1'b0, 5'd10, 5'd21, 16'hA5C3, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0, cause_wr = 1'b0, link = 1'b0, mdio_in = 1'b1;
  logic [31:0] cmd_wdata = '0, cause_wdata = '0, cmd_rdata, cause_rdata;
  logic        mdc, mdio_out, mdio_oe;

  int checks = 0, errors = 0;
  int rise_n = 0, cyc = 0, last_rise = -1, per_bad = 0;
  logic [63:0] cap_d, cap_oe;
  logic [15:0] resp = '0;

  always #2.5 clk = ~clk;

  mdio_mgmt_ctrl #(.MDC_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wdata),
    .cmd_rdata_o(cmd_rdata), .cause_wr_i(cause_wr), .cause_wdata_i(cause_wdata),
    .cause_rdata_o(cause_rdata), .link_i(link), .mdc_o(mdc), .mdio_o(mdio_out),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_in));

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge mdc) begin
    cap_d  = {cap_d[62:0], mdio_out};
    cap_oe = {cap_oe[62:0], mdio_oe};
    if (last_rise >= 0 && rise_n > 0 && (cyc - last_rise) != DIV) per_bad++;
    last_rise = cyc;
    rise_n++;
  end

  always @(negedge mdc) begin
    if (rise_n == 47)                     mdio_in = 1'b0;
    else if (rise_n >= 48 && rise_n <= 63) mdio_in = resp[63 - rise_n];
    else                                  mdio_in = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    rise_n = 0; last_rise = -1; cap_d = '0; cap_oe = '0;
    cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (cmd_rdata[28] && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic cause_write(input logic [31:0] w);
    @(negedge clk);
    cause_wr = 1'b1; cause_wdata = w;
    @(negedge clk);
    cause_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [63:0] exp_d, exp_oe;
    logic [31:0] exp_st;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cmd_rdata == 0 && cause_rdata == 0 && !mdc && !mdio_oe, "R1",
        {cmd_rdata, cause_rdata}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic rd; logic [4:0] ph, rg; logic [15:0] wd;
      {rd, ph, rg, wd, resp} = VEC[i];
      issue({5'b0, rd, rg, ph, wd});
      exp_st = {3'b000, 1'b1, 1'b0, rd, rg, ph, wd};
      chk(cmd_rdata == exp_st, "R5 fields while busy", cmd_rdata, exp_st);
      wait_idle(n);
      chk(n == 64 * DIV, "R2 busy length", n, 64 * DIV);
      chk(!mdc, "R2 mdc low when idle", mdc, 0);
      if (rd) begin
        exp_d  = {32'hFFFF_FFFF, 2'b01, 2'b10, ph, rg, 18'h0};
        exp_oe = {46'h3FFF_FFFF_FFFF, 18'h0};
        chk(cap_oe == exp_oe && (cap_d & exp_oe) == exp_d, "R4 read frame",
            cap_d & cap_oe, exp_d);
        exp_st = {3'b000, 1'b0, 1'b1, 1'b1, rg, ph, resp};
        chk(cmd_rdata == exp_st, "R5 read data and valid", cmd_rdata, exp_st);
      end else begin
        exp_d  = {32'hFFFF_FFFF, 2'b01, 2'b01, ph, rg, 2'b10, wd};
        exp_oe = '1;
        chk(cap_oe == exp_oe && cap_d == exp_d, "R3 write frame", cap_d, exp_d);
        exp_st = {3'b000, 1'b0, 1'b0, 1'b0, rg, ph, wd};
        chk(cmd_rdata == exp_st, "R7 no valid after write", cmd_rdata, exp_st);
      end
      chk(cause_rdata == 32'h2000_0000, "R8 done cause", cause_rdata, 32'h2000_0000);
      cause_write(32'h0);
      chk(cause_rdata == 0, "R10 zero clears", cause_rdata, 0);
    end
    chk(per_bad == 0, "R2 mdc period", per_bad, 0);

    // R7: valid set by last read, then cleared by a new accepted command
    issue({5'b0, 1'b1, 5'd3, 5'd4, 16'h0});
    wait_idle(n);
    chk(cmd_rdata[27], "R7 valid after read", cmd_rdata[27], 1);
    issue({5'b0, 1'b0, 5'd6, 5'd7, 16'h0BAD});
    chk(!cmd_rdata[27], "R7 valid cleared on accept", cmd_rdata[27], 0);

    // R6: write while busy is ignored
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = {5'b0, 1'b1, 5'd9, 5'd8, 16'h7777};
    @(negedge clk);
    cmd_wr = 1'b0;
    exp_st = {3'b000, 1'b1, 1'b0, 1'b0, 5'd6, 5'd7, 16'h0BAD};
    chk(cmd_rdata == exp_st, "R6 busy write ignored", cmd_rdata, exp_st);
    wait_idle(n);
    exp_d = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd7, 5'd6, 2'b10, 16'h0BAD};
    chk(cap_d == exp_d && cap_oe == '1, "R6 frame of first command", cap_d, exp_d);
    chk(cmd_rdata[15:0] == 16'h0BAD && !cmd_rdata[27], "R6 data kept",
        cmd_rdata, 32'h0BAD);
    cause_write(32'h0);

    // R9: link change both directions
    @(negedge clk); link = 1'b1;
    @(negedge clk);
    chk(cause_rdata == 32'h1000_0000, "R9 link rise", cause_rdata, 32'h1000_0000);
    cause_write(32'h0);
    chk(cause_rdata == 0, "R10 clear link", cause_rdata, 0);
    @(negedge clk); link = 1'b0;
    @(negedge clk);
    chk(cause_rdata[28], "R9 link fall", cause_rdata, 32'h1000_0000);

    // R10: selective clear keeps bits written 1
    issue({5'b0, 1'b0, 5'd1, 5'd1, 16'h0001});
    wait_idle(n);
    chk(cause_rdata == 32'h3000_0000, "R10 both set", cause_rdata, 32'h3000_0000);
    cause_write(32'h2000_0000);
    chk(cause_rdata == 32'h2000_0000, "R10 keep done bit", cause_rdata, 32'h2000_0000);
    cause_write(32'h0);
    chk(cause_rdata == 0 && !mdc && !mdio_oe, "R10 all clear idle", cause_rdata, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule